// File: doc/BRIEF.md
# Multiplexed External Memory Bus Interface

This block sits between an 8-bit processor core's data-move port and a set of package pins that carry a multiplexed address/data bus. The core presents an address, a write byte and a direction, then holds the request until a one-cycle done pulse. A 2-bit mode field decides whether the access goes to an on-chip RAM port or off-chip. An on-chip access takes one cycle and leaves the pins alone. An off-chip access runs a fixed sequence of phases. First the low address byte is placed on the shared bus with the address-latch strobe high. Then that address is held, the active-low read or write strobe is pulsed, the data is held, and the pins are released.

Outside an off-chip access, every bus and control pin simply reflects its port latch value, which software normally parks at logic 1. The per-pin push-pull/open-drain selection is not touched by the block and passes straight through. The state machine has six states. ST_IDLE moves to ST_LOCAL on an on-chip request or to ST_ADDR on an off-chip one. ST_LOCAL returns to ST_IDLE. ST_ADDR counts down its cycles and then moves to ST_AHOLD. ST_AHOLD moves to ST_STROBE. ST_STROBE counts down its cycles and then moves to ST_DHOLD. ST_DHOLD returns to ST_IDLE.

Top module: `xmem_bus_if`

## Requirements
- R1: cfg_mode selects routing: 2'b00 sends every access on-chip; 2'b01 and 2'b10 send addresses below RAM_BYTES (2048) on-chip and the rest off-chip; 2'b11 sends every access off-chip.
- R2: An off-chip access runs, from the cycle after acceptance: max(cfg_addr_clks,1) cycles with pad_ale high and the low address byte on pad_ad_o, then 1 address-hold cycle with pad_ale low and the address still driven, then max(cfg_strb_clks,1) strobe cycles, then 1 data-hold cycle, then release.
- R3: Read and write strobes are separate and active low. During an access they are never low together. A write pulls pad_wr_n low for the strobe cycles and drives the write byte on pad_ad_o through the strobe and data-hold cycles.
- R4: Whenever no off-chip access is active, pad_ale, pad_rd_n, pad_wr_n, pad_ad_o and pad_ah_o equal their latch inputs, and both enable buses are all ones.
- R5: During the strobe and data-hold cycles of a read, pad_ad_oe is all zeros.
- R6: In mode 2'b01 pad_ah_o keeps latch_ah during an off-chip access. In modes 2'b10 and 2'b11 it carries address bits [15:8] for the whole access. pad_ah_oe stays all ones throughout.
- R7: pad_mode_out equals pad_mode_in at all times.
- R8: Read data is taken from pad_ad_i at the end of the last strobe cycle and appears on req_rdata in the data-hold cycle. Values present on pad_ad_i in earlier or later cycles do not affect it.
- R9: req_done is a one-cycle pulse. It is high in the data-hold cycle of an off-chip access and in the cycle after acceptance of an on-chip access.
- R10: An on-chip access asserts ram_en (and ram_we for a write) in the accepting cycle, completes in the next cycle with req_rdata equal to ram_rdata, and never moves pad_ale, pad_rd_n or pad_wr_n off their latch values.
- R11: The on-chip RAM address is the low log2(RAM_BYTES) bits of req_addr, so in mode 2'b00 address 16'hFFFF reaches RAM location 11'h7FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Routing mode (R1) |
| cfg_addr_clks | input | CW | Address-phase length in clocks, 0 treated as 1 |
| cfg_strb_clks | input | CW | Strobe-phase length in clocks, 0 treated as 1 |
| req_valid | input | 1 | Core request, held until req_done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write byte |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Read byte, valid with req_done |
| ram_en | output | 1 | On-chip RAM enable |
| ram_we | output | 1 | On-chip RAM write enable |
| ram_addr | output | RAM_AW | On-chip RAM address |
| ram_wdata | output | DW | On-chip RAM write byte |
| ram_rdata | input | DW | On-chip RAM read byte, one cycle after ram_en |
| latch_ale | input | 1 | Parked value of the address-latch pin |
| latch_rd_n | input | 1 | Parked value of the read-strobe pin |
| latch_wr_n | input | 1 | Parked value of the write-strobe pin |
| latch_ad | input | DW | Parked values of the address/data pins |
| latch_ah | input | HW | Parked values of the high-address pins |
| pad_ale | output | 1 | Address-latch strobe pin |
| pad_rd_n | output | 1 | Read strobe pin, active low |
| pad_wr_n | output | 1 | Write strobe pin, active low |
| pad_ad_o | output | DW | Address/data pin outputs |
| pad_ad_oe | output | DW | Address/data pin output enables |
| pad_ad_i | input | DW | Address/data pin inputs |
| pad_ah_o | output | HW | High-address pin outputs |
| pad_ah_oe | output | HW | High-address pin output enables |
| pad_mode_in | input | NPIN | Per-pin push-pull select |
| pad_mode_out | output | NPIN | Per-pin push-pull select to the pads |

## Verification
On every cycle the assertions check four things: the strobes are never low together during an access, the bus is released whenever a read strobe is active, the pins show their latch values whenever the block is idle, and done is a single pulse. They also check that the strobe phase is always entered from the address hold and that every on-chip enable is followed by completion. Phase lengths, the exact cycle in which read data is sampled, the routing split at 2048 in each mode, high-byte behaviour per mode and address wrap into the RAM port can only be shown by the directed scenarios.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        MODE_INTERNAL     = 2'b00,
        MODE_SPLIT_FLAT   = 2'b01,
        MODE_SPLIT_BANKED = 2'b10,
        MODE_EXTERNAL     = 2'b11
    } xmem_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_ADDR,
        ST_AHOLD,
        ST_STROBE,
        ST_DHOLD
    } xmem_state_e;

endpackage

// File: rtl/xmem_route.sv
module xmem_route
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int RAM_BYTES = 2048,
    localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
    input  logic [1:0]        mode,
    input  logic [AW-1:0]     addr,
    output logic              is_ext,
    output logic              hi_drive,
    output logic [RAM_AW-1:0] local_addr
);

    logic above;

    always_comb begin
        above      = (int'(addr) >= RAM_BYTES);
        local_addr = addr[RAM_AW-1:0];
        is_ext     = 1'b0;
        hi_drive   = 1'b0;
        unique case (xmem_mode_e'(mode))
            MODE_INTERNAL: begin
                is_ext   = 1'b0;
                hi_drive = 1'b0;
            end
            MODE_SPLIT_FLAT: begin
                is_ext   = above;
                hi_drive = 1'b0;
            end
            MODE_SPLIT_BANKED: begin
                is_ext   = above;
                hi_drive = 1'b1;
            end
            MODE_EXTERNAL: begin
                is_ext   = 1'b1;
                hi_drive = 1'b1;
            end
            default: begin
                is_ext   = 1'b0;
                hi_drive = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          is_ext,
    input  logic [CW-1:0] addr_clks,
    input  logic [CW-1:0] strb_clks,
    output xmem_state_e   state,
    output logic          accept,
    output logic          busy,
    output logic          last_strobe,
    output logic          done
);

    xmem_state_e   nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [CW-1:0] a_len, s_len;

    assign a_len = (addr_clks == '0) ? CW'(1) : addr_clks;
    assign s_len = (strb_clks == '0) ? CW'(1) : strb_clks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (is_ext) begin
                        nxt     = ST_ADDR;
                        cnt_nxt = a_len - CW'(1);
                    end else begin
                        nxt = ST_LOCAL;
                    end
                end
            end
            ST_LOCAL:  nxt = ST_IDLE;
            ST_ADDR: begin
                if (cnt == '0) nxt = ST_AHOLD;
                else           cnt_nxt = cnt - CW'(1);
            end
            ST_AHOLD: begin
                nxt     = ST_STROBE;
                cnt_nxt = s_len - CW'(1);
            end
            ST_STROBE: begin
                if (cnt == '0) nxt = ST_DHOLD;
                else           cnt_nxt = cnt - CW'(1);
            end
            ST_DHOLD:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept      = (state == ST_IDLE) && req_valid;
        busy        = (state == ST_ADDR) || (state == ST_AHOLD) ||
                      (state == ST_STROBE) || (state == ST_DHOLD);
        last_strobe = (state == ST_STROBE) && (cnt == '0);
        done        = (state == ST_LOCAL) || (state == ST_DHOLD);
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_strobe_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE) |-> ($past(state) == ST_AHOLD || $past(state) == ST_STROBE));

endmodule

// File: rtl/xmem_pins.sv
module xmem_pins
    import xmem_pkg::*;
#(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xmem_state_e       state,
    input  logic              wr,
    input  logic              hi_drive,
    input  logic [DW-1:0]     lo_addr,
    input  logic [HW-1:0]     hi_addr,
    input  logic [DW-1:0]     wdata,
    input  logic              latch_ale,
    input  logic              latch_rd_n,
    input  logic              latch_wr_n,
    input  logic [DW-1:0]     latch_ad,
    input  logic [HW-1:0]     latch_ah,
    output logic              pad_ale,
    output logic              pad_rd_n,
    output logic              pad_wr_n,
    output logic [DW-1:0]     pad_ad_o,
    output logic [DW-1:0]     pad_ad_oe,
    output logic [HW-1:0]     pad_ah_o,
    output logic [HW-1:0]     pad_ah_oe
);

    logic owned;

    always_comb begin
        owned     = 1'b1;
        pad_ale   = 1'b0;
        pad_rd_n  = 1'b1;
        pad_wr_n  = 1'b1;
        pad_ad_o  = lo_addr;
        pad_ad_oe = '1;
        unique case (state)
            ST_ADDR: begin
                pad_ale = 1'b1;
            end
            ST_AHOLD: begin
                pad_ale = 1'b0;
            end
            ST_STROBE: begin
                pad_rd_n  = wr;
                pad_wr_n  = !wr;
                pad_ad_o  = wdata;
                pad_ad_oe = wr ? '1 : '0;
            end
            ST_DHOLD: begin
                pad_ad_o  = wdata;
                pad_ad_oe = wr ? '1 : '0;
            end
            default: begin
                owned     = 1'b0;
                pad_ale   = latch_ale;
                pad_rd_n  = latch_rd_n;
                pad_wr_n  = latch_wr_n;
                pad_ad_o  = latch_ad;
                pad_ad_oe = '1;
            end
        endcase
        pad_ah_o  = (owned && hi_drive) ? hi_addr : latch_ah;
        pad_ah_oe = '1;
    end

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_ADDR, ST_AHOLD, ST_STROBE, ST_DHOLD}) |-> (pad_rd_n || pad_wr_n));

    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state inside {ST_STROBE, ST_DHOLD}) && !pad_rd_n) |-> (pad_ad_oe == '0));

    assert_idle_park_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_IDLE, ST_LOCAL}) |->
            (pad_ad_o == latch_ad && pad_ah_o == latch_ah && pad_ale == latch_ale &&
             pad_ad_oe == '1));

endmodule

// File: rtl/xmem_bus_if.sv
module xmem_bus_if
    import xmem_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 8,
    parameter int CW        = 4,
    parameter int RAM_BYTES = 2048,
    localparam int RAM_AW   = $clog2(RAM_BYTES),
    localparam int HW       = AW - DW,
    localparam int NPIN     = 3 + DW + HW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [CW-1:0]     cfg_addr_clks,
    input  logic [CW-1:0]     cfg_strb_clks,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              req_done,
    output logic [DW-1:0]     req_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata,
    input  logic              latch_ale,
    input  logic              latch_rd_n,
    input  logic              latch_wr_n,
    input  logic [DW-1:0]     latch_ad,
    input  logic [HW-1:0]     latch_ah,
    output logic              pad_ale,
    output logic              pad_rd_n,
    output logic              pad_wr_n,
    output logic [DW-1:0]     pad_ad_o,
    output logic [DW-1:0]     pad_ad_oe,
    input  logic [DW-1:0]     pad_ad_i,
    output logic [HW-1:0]     pad_ah_o,
    output logic [HW-1:0]     pad_ah_oe,
    input  logic [NPIN-1:0]   pad_mode_in,
    output logic [NPIN-1:0]   pad_mode_out
);

    logic              is_ext, hi_drive_now;
    logic [RAM_AW-1:0] local_addr;
    xmem_state_e       state;
    logic              accept, busy, last_strobe, done;

    logic [AW-1:0]     cap_addr;
    logic [DW-1:0]     cap_wdata;
    logic              cap_wr, cap_hi;
    logic [DW-1:0]     rdata_q;

    xmem_route #(.AW(AW), .RAM_BYTES(RAM_BYTES)) u_route (
        .mode       (cfg_mode),
        .addr       (req_addr),
        .is_ext     (is_ext),
        .hi_drive   (hi_drive_now),
        .local_addr (local_addr)
    );

    xmem_seq #(.CW(CW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .is_ext      (is_ext),
        .addr_clks   (cfg_addr_clks),
        .strb_clks   (cfg_strb_clks),
        .state       (state),
        .accept      (accept),
        .busy        (busy),
        .last_strobe (last_strobe),
        .done        (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_wr    <= 1'b0;
            cap_hi    <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (accept && is_ext) begin
                cap_addr  <= req_addr;
                cap_wdata <= req_wdata;
                cap_wr    <= req_write;
                cap_hi    <= hi_drive_now;
            end
            if (last_strobe && !cap_wr) begin
                rdata_q <= pad_ad_i;
            end
        end
    end

    xmem_pins #(.DW(DW), .HW(HW)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .wr         (cap_wr),
        .hi_drive   (cap_hi),
        .lo_addr    (cap_addr[DW-1:0]),
        .hi_addr    (cap_addr[AW-1:DW]),
        .wdata      (cap_wdata),
        .latch_ale  (latch_ale),
        .latch_rd_n (latch_rd_n),
        .latch_wr_n (latch_wr_n),
        .latch_ad   (latch_ad),
        .latch_ah   (latch_ah),
        .pad_ale    (pad_ale),
        .pad_rd_n   (pad_rd_n),
        .pad_wr_n   (pad_wr_n),
        .pad_ad_o   (pad_ad_o),
        .pad_ad_oe  (pad_ad_oe),
        .pad_ah_o   (pad_ah_o),
        .pad_ah_oe  (pad_ah_oe)
    );

    always_comb begin
        ram_en       = accept && !is_ext;
        ram_we       = accept && !is_ext && req_write;
        ram_addr     = local_addr;
        ram_wdata    = req_wdata;
        req_done     = done;
        req_rdata    = (state == ST_LOCAL) ? ram_rdata : rdata_q;
        pad_mode_out = pad_mode_in;
    end

    assert_local_finishes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> (req_done && !busy));

    assert_pins_idle_on_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |=> (pad_rd_n == latch_rd_n && pad_wr_n == latch_wr_n));

endmodule

// File: tb/test_xmem_bus_if.sv
`timescale 1ns/1ps
module test_xmem_bus_if;

    localparam int AW = 16, DW = 8, CW = 4, RAM_BYTES = 2048;
    localparam int RAM_AW = 11, HW = 8, NPIN = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]        cfg_mode = 2'b11;
    logic [CW-1:0]     cfg_addr_clks = '0, cfg_strb_clks = '0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              req_done;
    logic [DW-1:0]     req_rdata;
    logic              ram_en, ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [DW-1:0]     ram_wdata;
    logic [DW-1:0]     ram_rdata = '0;
    logic              latch_ale = 1'b1, latch_rd_n = 1'b1, latch_wr_n = 1'b1;
    logic [DW-1:0]     latch_ad = 8'hA5;
    logic [HW-1:0]     latch_ah = 8'h3C;
    logic              pad_ale, pad_rd_n, pad_wr_n;
    logic [DW-1:0]     pad_ad_o, pad_ad_oe;
    logic [DW-1:0]     pad_ad_i = '0;
    logic [HW-1:0]     pad_ah_o, pad_ah_oe;
    logic [NPIN-1:0]   pad_mode_in = 19'h5_A5A5;
    logic [NPIN-1:0]   pad_mode_out;

    int vectors = 0;
    int misses  = 0;

    xmem_bus_if i_xmem_bus_if (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_addr_clks(cfg_addr_clks), .cfg_strb_clks(cfg_strb_clks),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .latch_ale(latch_ale), .latch_rd_n(latch_rd_n), .latch_wr_n(latch_wr_n),
        .latch_ad(latch_ad), .latch_ah(latch_ah),
        .pad_ale(pad_ale), .pad_rd_n(pad_rd_n), .pad_wr_n(pad_wr_n),
        .pad_ad_o(pad_ad_o), .pad_ad_oe(pad_ad_oe), .pad_ad_i(pad_ad_i),
        .pad_ah_o(pad_ah_o), .pad_ah_oe(pad_ah_oe),
        .pad_mode_in(pad_mode_in), .pad_mode_out(pad_mode_out)
    );

    // On-chip RAM model: synchronous, one cycle read latency
    logic [DW-1:0] mem [RAM_BYTES];
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic chk_parked(input string rq);
        chk({rq, " ale"},  32'(pad_ale),   32'(latch_ale));
        chk({rq, " rd_n"}, 32'(pad_rd_n),  32'(latch_rd_n));
        chk({rq, " wr_n"}, 32'(pad_wr_n),  32'(latch_wr_n));
        chk({rq, " ad"},   32'(pad_ad_o),  32'(latch_ad));
        chk({rq, " ad_oe"},32'(pad_ad_oe), 32'hFF);
        chk({rq, " ah"},   32'(pad_ah_o),  32'(latch_ah));
        chk({rq, " ah_oe"},32'(pad_ah_oe), 32'hFF);
    endtask

    // Off-chip access, checked cycle by cycle (R2, R3, R5, R6, R8, R9)
    task automatic ext_access(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                              input logic [7:0] rv, input int a, input int s,
                              input logic hi_drv, input string tag);
        int al = (a == 0) ? 1 : a;
        int sl = (s == 0) ? 1 : s;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        cfg_addr_clks = CW'(a); cfg_strb_clks = CW'(s); pad_ad_i = ~rv;
        #0.1;
        chk({tag, " R1 routed off-chip, no ram_en"}, 32'(ram_en), 0);
        for (int k = 0; k <= al + sl + 1; k++) begin
            @(negedge clk);
            pad_ad_i = (k == al + sl) ? rv : ~rv;
            #0.1;
            begin
                logic strobe = (k > al) && (k <= al + sl);
                logic aphase = (k <= al);
                chk({tag, " R2 ale"}, 32'(pad_ale), 32'(k < al));
                chk({tag, " R3 rd_n"}, 32'(pad_rd_n), 32'(!(strobe && !wr)));
                chk({tag, " R3 wr_n"}, 32'(pad_wr_n), 32'(!(strobe && wr)));
                chk({tag, " R5 ad_oe"}, 32'(pad_ad_oe), (aphase || wr) ? 32'hFF : 32'h00);
                if (aphase) chk({tag, " R2 low address"}, 32'(pad_ad_o), 32'(addr[7:0]));
                else if (wr) chk({tag, " R3 write data"}, 32'(pad_ad_o), 32'(wd));
                chk({tag, " R6 high byte"}, 32'(pad_ah_o), hi_drv ? 32'(addr[15:8]) : 32'(latch_ah));
                chk({tag, " R6 high oe"}, 32'(pad_ah_oe), 32'hFF);
                chk({tag, " R9 done timing"}, 32'(req_done), 32'(k == al + sl + 1));
                if (k == al + sl + 1 && !wr) chk({tag, " R8 read data"}, 32'(req_rdata), 32'(rv));
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        #0.1;
        chk({tag, " R9 done single pulse"}, 32'(req_done), 0);
        chk_parked({tag, " R4 released"});
    endtask

    // On-chip access (R10, R11)
    task automatic local_access(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                                input logic [7:0] exp_rd, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        #0.1;
        chk({tag, " R10 ram_en"}, 32'(ram_en), 1);
        chk({tag, " R10 ram_we"}, 32'(ram_we), 32'(wr));
        chk({tag, " R11 ram_addr"}, 32'(ram_addr), 32'(addr[10:0]));
        @(negedge clk);
        #0.1;
        chk({tag, " R10 done next cycle"}, 32'(req_done), 1);
        if (!wr) chk({tag, " R10 read data"}, 32'(req_rdata), 32'(exp_rd));
        chk_parked({tag, " R10 pins untouched"});
        req_valid = 1'b0;
        @(negedge clk);
        #0.1;
        chk({tag, " R9 done single pulse"}, 32'(req_done), 0);
    endtask

    task automatic t_reset;
        #0.1;
        chk("R9 done low in reset", 32'(req_done), 0);
        chk_parked("R4 parked in reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.1;
        chk_parked("R4 parked after reset");
    endtask

    task automatic t_park_and_mode;
        @(negedge clk);
        latch_ale = 1'b0; latch_rd_n = 1'b0; latch_wr_n = 1'b1;
        latch_ad = 8'h5A; latch_ah = 8'hC3; pad_mode_in = 19'h2_5A3C;
        #0.1;
        chk_parked("R4 new latch values");
        chk("R7 mode pass-through", 32'(pad_mode_out), 32'h2_5A3C);
        pad_mode_in = 19'h7_0F0F;
        #0.1;
        chk("R7 mode pass-through 2", 32'(pad_mode_out), 32'h7_0F0F);
        latch_ale = 1'b1; latch_rd_n = 1'b1; latch_wr_n = 1'b1;
        latch_ad = 8'hA5; latch_ah = 8'h3C;
    endtask

    task automatic t_external_mode;
        cfg_mode = 2'b11;
        ext_access(1'b1, 16'h1234, 8'h9E, 8'h00, 2, 3, 1'b1, "ext write");
        ext_access(1'b0, 16'h00F0, 8'h00, 8'h6B, 1, 1, 1'b1, "ext read low addr");
        ext_access(1'b0, 16'hBEEF, 8'h00, 8'hC4, 0, 0, 1'b1, "ext read zero cfg");
        ext_access(1'b0, 16'h4321, 8'h00, 8'h17, 3, 4, 1'b1, "ext read long");
    endtask

    task automatic t_split_flat;
        cfg_mode = 2'b01;
        local_access(1'b1, 16'h07FF, 8'h81, 8'h00, "flat 07FF on-chip R1");
        ext_access(1'b1, 16'h0800, 8'h42, 8'h00, 1, 2, 1'b0, "flat 0800 off-chip R1");
        ext_access(1'b0, 16'hF00D, 8'h00, 8'h99, 2, 1, 1'b0, "flat read hi latch");
        local_access(1'b0, 16'h07FF, 8'h00, 8'h81, "flat readback");
    endtask

    task automatic t_split_banked;
        cfg_mode = 2'b10;
        ext_access(1'b0, 16'h0800, 8'h00, 8'h3E, 1, 1, 1'b1, "banked 0800");
        ext_access(1'b1, 16'hA7C2, 8'h5D, 8'h00, 2, 2, 1'b1, "banked write");
        local_access(1'b1, 16'h0010, 8'h77, 8'h00, "banked 0010 on-chip R1");
        local_access(1'b0, 16'h0010, 8'h00, 8'h77, "banked readback");
    endtask

    task automatic t_internal_mode;
        cfg_mode = 2'b00;
        local_access(1'b1, 16'hFFFF, 8'h44, 8'h00, "internal FFFF R11");
        local_access(1'b0, 16'h07FF, 8'h00, 8'h44, "internal wrap readback R11");
        local_access(1'b0, 16'h0800, 8'h00, 8'h81, "internal 0800 wraps to 000 R1");
    endtask

    initial begin
        // location 0 preset through a write for the wrap check
        t_reset();
        t_park_and_mode();
        cfg_mode = 2'b00;
        local_access(1'b1, 16'h0000, 8'h81, 8'h00, "internal preset 000");
        t_external_mode();
        t_split_flat();
        t_split_banked();
        t_internal_mode();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #100000;
        misses++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule